// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block moderates receive-completion interrupts for a set of receive descriptor rings. The default build has seventeen of them: sixteen priority rings plus one default ring at the highest index. Each ring sees a one-cycle pulse for every packet that completes on it. The ring raises its own coalesced interrupt line once enough packets have built up, or once a programmed time has passed since the first unserviced packet. The line stays high until software acknowledges that ring.

Time is measured in coarse ticks from one prescaler shared by all rings. The default divide ratio is 1024. From a 125 MHz reference that gives a tick of about 8.192 us. With a frame threshold of one, the coalesced line rises in exactly the cycle a per-packet completion interrupt would, so software can keep the per-packet and per-buffer sources masked. A small write/read port selects a ring by index and one of three views of it: frame threshold, timeout or pending count.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset, every interrupt line is low and every ring's threshold, timeout and pending count read as zero.
- R2: With a nonzero threshold T, a ring's line rises on the clock edge that captures the packet bringing its pending count to T. It stays high until that ring is acknowledged.
- R3: With threshold 1, the line rises on the edge that captures each packet, one cycle after the pulse is driven, exactly like a per-packet done event.
- R4: With a nonzero timeout N and at least one pending packet, the line rises on the N-th prescaler tick after the edge that captured the first packet of the batch. The latency is (N-1)*PRESCALE+1 to N*PRESCALE cycles.
- R5: A ring's timer advances only while packets are pending. A ring with no pending packets never fires on timeout.
- R6: A threshold of 0 disables the count path. A timeout of 0 disables the timer path. With both at 0 the ring never interrupts, although its pending count still grows.
- R7: Acknowledging a ring clears its line, its pending count and its timer on one edge. A packet captured on the same edge becomes the first of the next batch, giving a pending count of 1.
- R8: Register port: selector 0 is the frame threshold (THR_W bits). Selector 1 is the timeout, held in bits 15:0; writes to bits 31:16 are ignored and those bits read as 0. Selector 2 is the read-only pending count; writes to it are ignored. Ring indices at or above NUM_RINGS ignore writes and read 0.
- R9: Rings are independent. Traffic, configuration and acknowledges on one ring never change another ring's line.
- R10: One prescaler ticks once every PRESCALE cycles for all rings. Two rings with equal timeouts whose first packets land on the same edge fire on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_done_i | input | NUM_RINGS | One-cycle pulse per completed packet, one bit per ring |
| ring_ack_i | input | NUM_RINGS | Software acknowledge, one bit per ring |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register selector: 0 threshold, 1 timeout, 2 pending count |
| cfg_ring_i | input | RING_W | Ring index for read and write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data (combinational from selector and index) |
| irq_o | output | NUM_RINGS | Coalesced done interrupt, one bit per ring |

## Verification
The bench keeps the default seventeen rings and an 8-bit threshold. That lets it reach the default ring at index 16, an unused index above it, and truncation of an oversized threshold. It sets PRESCALE to 4, so a multi-tick timeout window ends within about a dozen cycles. It can then check both ends of the latency bound, and check that two rings fire together from the shared tick, in a short run.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_THR  = 2'd0,
    SEL_TMO  = 2'd1,
    SEL_PEND = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rxc_prescaler.sv
module rxc_prescaler #(
  parameter int DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  if (DIV <= 1) begin : g_pass
    assign tick_o = 1'b1;
  end else begin : g_div
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
  end
endmodule

// File: rtl/rxc_cfg_regs.sv
module rxc_cfg_regs
  import rxc_pkg::*;
#(
  parameter int NUM_RINGS = 17,
  parameter int THR_W     = 8,
  parameter int TMO_W     = 16,
  parameter int CNT_W     = 16,
  parameter int RING_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [RING_W-1:0] ring_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  pend_i [NUM_RINGS],
  output logic [REG_W-1:0]  rdata_o,
  output logic [THR_W-1:0]  thr_o  [NUM_RINGS],
  output logic [TMO_W-1:0]  tmo_o  [NUM_RINGS]
);
  logic [THR_W-1:0] thr_q [NUM_RINGS];
  logic [THR_W-1:0] thr_d [NUM_RINGS];
  logic [TMO_W-1:0] tmo_q [NUM_RINGS];
  logic [TMO_W-1:0] tmo_d [NUM_RINGS];
  logic             ring_ok;
  logic             wr_en;
  reg_sel_e         sel;
  logic             unused_wbits;

  assign sel          = reg_sel_e'(sel_i);
  assign ring_ok      = (int'(ring_i) < NUM_RINGS);
  assign wr_en        = we_i && ring_ok && (sel == SEL_THR || sel == SEL_TMO);
  assign unused_wbits = ^wdata_i[REG_W-1:TMO_W];

  // next-state: only the addressed field of the addressed ring changes
  always_comb begin
    thr_d = thr_q;
    tmo_d = tmo_q;
    if (wr_en) begin
      if (sel == SEL_THR) thr_d[ring_i] = wdata_i[THR_W-1:0];
      if (sel == SEL_TMO) tmo_d[ring_i] = wdata_i[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_RINGS; r++) begin
        thr_q[r] <= '0;
        tmo_q[r] <= '0;
      end
    end else if (wr_en) begin
      thr_q <= thr_d;
      tmo_q <= tmo_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ring_ok) begin
      case (sel)
        SEL_THR:  rdata_o = REG_W'(thr_q[ring_i]);
        SEL_TMO:  rdata_o = REG_W'(tmo_q[ring_i]);
        SEL_PEND: rdata_o = REG_W'(pend_i[ring_i]);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign thr_o = thr_q;
  assign tmo_o = tmo_q;
endmodule

// File: rtl/rxc_ring_ctl.sv
module rxc_ring_ctl #(
  parameter int THR_W = 8,
  parameter int TMO_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pkt_i,
  input  logic             ack_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pend_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TMO_W-1:0] TMR_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
  logic [TMO_W-1:0] tmr_q, tmr_base, tmr_inc, tmr_d;
  logic             irq_q, irq_d;
  logic             cnt_hit, tmo_hit, have_pend;
  logic             cnt_en, tmr_en, irq_en;

  // acknowledge wipes the batch first; a same-edge packet then starts a new one
  always_comb begin
    cnt_base  = ack_i ? '0 : cnt_q;
    tmr_base  = ack_i ? '0 : tmr_q;
    have_pend = (cnt_base != '0);

    cnt_d = cnt_base;
    if (pkt_i && cnt_base != CNT_MAX) cnt_d = cnt_base + 1'b1;

    tmr_inc = (tmr_base == TMR_MAX) ? tmr_base : tmr_base + 1'b1;
    tmr_d   = (tick_i && have_pend) ? tmr_inc : tmr_base;

    cnt_hit = (thr_i != '0) && (cnt_d >= CNT_W'(thr_i));
    tmo_hit = (tmo_i != '0) && have_pend && tick_i && (tmr_inc >= tmo_i);

    irq_d = (irq_q && !ack_i) || cnt_hit || tmo_hit;

    cnt_en = ack_i || pkt_i;
    tmr_en = ack_i || (tick_i && have_pend);
    irq_en = ack_i || cnt_hit || tmo_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (tmr_en) tmr_q <= tmr_d;
      if (irq_en) irq_q <= irq_d;
    end
  end

  assign irq_o  = irq_q;
  assign pend_o = cnt_q;
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
  import rxc_pkg::*;
#(
  parameter int NUM_RINGS = 17,
  parameter int THR_W     = 8,
  parameter int TMO_W     = 16,
  parameter int CNT_W     = 16,
  parameter int PRESCALE  = 1024,
  parameter int RING_W    = $clog2(NUM_RINGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] pkt_done_i,
  input  logic [NUM_RINGS-1:0] ring_ack_i,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_sel_i,
  input  logic [RING_W-1:0]    cfg_ring_i,
  input  logic [REG_W-1:0]     cfg_wdata_i,
  output logic [REG_W-1:0]     cfg_rdata_o,
  output logic [NUM_RINGS-1:0] irq_o
);
  logic             tick_w;
  logic [THR_W-1:0] thr_w  [NUM_RINGS];
  logic [TMO_W-1:0] tmo_w  [NUM_RINGS];
  logic [CNT_W-1:0] pend_w [NUM_RINGS];

  rxc_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  rxc_cfg_regs #(
    .NUM_RINGS (NUM_RINGS),
    .THR_W     (THR_W),
    .TMO_W     (TMO_W),
    .CNT_W     (CNT_W),
    .RING_W    (RING_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .ring_i  (cfg_ring_i),
    .wdata_i (cfg_wdata_i),
    .pend_i  (pend_w),
    .rdata_o (cfg_rdata_o),
    .thr_o   (thr_w),
    .tmo_o   (tmo_w)
  );

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    rxc_ring_ctl #(
      .THR_W (THR_W),
      .TMO_W (TMO_W),
      .CNT_W (CNT_W)
    ) u_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_w),
      .pkt_i  (pkt_done_i[r]),
      .ack_i  (ring_ack_i[r]),
      .thr_i  (thr_w[r]),
      .tmo_i  (tmo_w[r]),
      .irq_o  (irq_o[r]),
      .pend_o (pend_w[r])
    );
  end
endmodule

// File: rtl/rx_irq_coalescer_chk.sv
module rx_irq_coalescer_chk #(
  parameter int NUM_RINGS = 17,
  parameter int PRESCALE  = 1024
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_RINGS-1:0] pkt_done_i,
  input logic [NUM_RINGS-1:0] ring_ack_i,
  input logic [NUM_RINGS-1:0] irq_o,
  input logic                 tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] GAP_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  // R10
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == GAP_LAST));

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_chk
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_ack_i[r] && !pkt_done_i[r] |=> !irq_o[r]);

    // R2
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[r] && !ring_ack_i[r] |=> irq_o[r]);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[r]) |-> ($past(pkt_done_i[r]) || $past(tick)));
  end
endmodule

bind rx_irq_coalescer rx_irq_coalescer_chk #(
  .NUM_RINGS (NUM_RINGS),
  .PRESCALE  (PRESCALE)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_done_i (pkt_done_i),
  .ring_ack_i (ring_ack_i),
  .irq_o      (irq_o),
  .tick       (tick_w)
);

// File: tb/rx_irq_coalescer_tb_top.sv
module rx_irq_coalescer_tb_top;
  localparam int NR = 17;
  localparam int PS = 4;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] pkt_done = '0;
  logic [NR-1:0] ring_ack = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [RW-1:0] cfg_ring = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NR-1:0] irq;

  rx_irq_coalescer #(
    .NUM_RINGS (NR),
    .THR_W     (8),
    .TMO_W     (16),
    .CNT_W     (16),
    .PRESCALE  (PS),
    .RING_W    (RW)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_done_i  (pkt_done),
    .ring_ack_i  (ring_ack),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_ring_i  (cfg_ring),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .irq_o       (irq)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int    ring;
    logic  val;
    int    due;
    string tag;
  } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares queued line expectations when they fall due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      mon_e = sbq.pop_front();
      check(mon_e.tag, {31'd0, irq[mon_e.ring]}, {31'd0, mon_e.val});
    end
  end

  task automatic push_exp(input int ring, input logic val, input string tag);
    exp_t e;
    e.ring = ring; e.val = val; e.due = cyc + 1; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic send_pkt(input int ring, input logic exp_irq, input string tag);
    @(negedge clk);
    pkt_done[ring] = 1'b1;
    push_exp(ring, exp_irq, tag);
    @(negedge clk);
    pkt_done = '0;
  endtask

  task automatic send_ack(input int ring, input bit with_pkt, input logic exp_irq, input string tag);
    @(negedge clk);
    ring_ack[ring] = 1'b1;
    pkt_done[ring] = with_pkt;
    push_exp(ring, exp_irq, tag);
    @(negedge clk);
    ring_ack = '0;
    pkt_done = '0;
  endtask

  task automatic reg_wr(input int sel, input int ring, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_ring = RW'(ring); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input int sel, input int ring, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_sel = 2'(sel); cfg_ring = RW'(ring);
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse one packet on a ring and count edges until its line rises
  task automatic timeout_lat(input int ring, input int tmo, input string tag);
    int lat;
    @(negedge clk);
    pkt_done[ring] = 1'b1;
    @(negedge clk);
    pkt_done = '0;
    lat = 0;
    while (!irq[ring] && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(tag, {31'd0, (lat >= (tmo - 1) * PS + 1) && (lat <= tmo * PS)}, 32'd1);
    if (lat < (tmo - 1) * PS + 1 || lat > tmo * PS)
      $display("  latency %0d, window %0d..%0d", lat, (tmo - 1) * PS + 1, tmo * PS);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq after reset", {15'd0, irq}, 32'd0);
    reg_rd(0, 0, 32'd0, "R1 threshold ring0");
    reg_rd(1, 16, 32'd0, "R1 timeout ring16");
    reg_rd(2, 3, 32'd0, "R1 pending ring3");

    // R6 both paths disabled: count still grows, line stays low
    for (int i = 0; i < 10; i++) send_pkt(7, 1'b0, "R6 both zero");
    idle(6 * PS);
    check("R6 both zero after wait", {31'd0, irq[7]}, 32'd0);
    reg_rd(2, 7, 32'd10, "R6 pending grows");

    // R2 count path, threshold 4 on ring 3
    reg_wr(0, 3, 32'd4);
    send_pkt(3, 1'b0, "R2 pkt1");
    send_pkt(3, 1'b0, "R2 pkt2");
    send_pkt(3, 1'b0, "R2 pkt3");
    send_pkt(3, 1'b1, "R2 pkt4 reaches threshold");
    idle(3);
    check("R2 line held", {31'd0, irq[3]}, 32'd1);
    check("R9 ring4 untouched", {31'd0, irq[4]}, 32'd0);

    // R7 acknowledge
    send_ack(3, 1'b0, 1'b0, "R7 ack clears line");
    reg_rd(2, 3, 32'd0, "R7 ack clears count");
    for (int i = 0; i < 4; i++) send_pkt(3, (i == 3), "R7 refill");
    send_ack(3, 1'b1, 1'b0, "R7 ack with packet");
    reg_rd(2, 3, 32'd1, "R7 same-edge packet counts");
    send_pkt(3, 1'b0, "R7 next batch 2");
    send_pkt(3, 1'b0, "R7 next batch 3");
    send_pkt(3, 1'b1, "R7 next batch 4");
    send_ack(3, 1'b0, 1'b0, "R7 ack");

    // R3 threshold one on default ring
    reg_wr(0, 16, 32'd1);
    send_pkt(16, 1'b1, "R3 thr1 single packet");
    send_ack(16, 1'b1, 1'b1, "R3 ack with packet refires");
    reg_rd(2, 16, 32'd1, "R3 pending after refire");
    send_ack(16, 1'b0, 1'b0, "R3 ack alone");

    // R6 timer disabled: count path alone, no expiry
    send_pkt(3, 1'b0, "R6 tmo0 pkt");
    idle(10 * PS);
    check("R6 tmo0 no expiry", {31'd0, irq[3]}, 32'd0);
    send_ack(3, 1'b0, 1'b0, "R6 cleanup");

    // R4 timeout windows
    reg_wr(1, 5, 32'd3);
    timeout_lat(5, 3, "R4 tmo3 latency window");
    send_ack(5, 1'b0, 1'b0, "R4 ack");
    reg_wr(1, 5, 32'd1);
    timeout_lat(5, 1, "R4 tmo1 latency window");
    send_ack(5, 1'b0, 1'b0, "R4 ack tmo1");

    // R5 no pending, no expiry
    reg_wr(1, 6, 32'd2);
    idle(5 * PS);
    check("R5 idle ring6", {31'd0, irq[6]}, 32'd0);
    check("R5 idle ring5 after ack", {31'd0, irq[5]}, 32'd0);

    // R10 shared prescaler: equal timeouts, same start edge
    reg_wr(1, 5, 32'd2);
    @(negedge clk);
    pkt_done[5] = 1'b1; pkt_done[6] = 1'b1;
    @(negedge clk);
    pkt_done = '0;
    for (int i = 0; i < 40 && !(irq[5] || irq[6]); i++) @(negedge clk);
    check("R10 ring5 fired", {31'd0, irq[5]}, 32'd1);
    check("R10 ring6 same edge", {31'd0, irq[6]}, 32'd1);
    send_ack(5, 1'b0, 1'b0, "R9 ack ring5");
    check("R9 ring6 kept", {31'd0, irq[6]}, 32'd1);
    send_ack(6, 1'b0, 1'b0, "R9 ack ring6");

    // R8 register port
    reg_wr(1, 2, 32'hABCD_0005);
    reg_rd(1, 2, 32'h0000_0005, "R8 timeout upper bits dropped");
    reg_wr(0, 2, 32'h0000_01FF);
    reg_rd(0, 2, 32'h0000_00FF, "R8 threshold width");
    reg_wr(2, 7, 32'd0);
    reg_rd(2, 7, 32'd10, "R8 pending write ignored");
    reg_wr(0, 20, 32'd3);
    reg_rd(0, 20, 32'd0, "R8 out of range index");
    reg_rd(0, 3, 32'd4, "R8 neighbour threshold intact");

    idle(4);
    check("R8 scoreboard drained", sbq.size(), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule